// File: doc/BRIEF.md
# Programmable Power-Sequencing Macrocell Array

This block holds a row of programmable product-term cells, one for each output driver of a supply supervisor. Each cell forms a wide AND over any chosen subset of the system's input signals and of the other cells' outputs. Any term can be inverted on its way in. Supply fault flags, watchdog flags and general logic inputs arrive on one external input vector. The cell's result does not reach its output directly. It first passes through an edge-delay stage, and the rising and falling transitions of that stage have separately programmed delays, counted in millisecond tick pulses.

Every cell's final output feeds back as a selectable term to the other cells. Sequencing schemes are built from that feedback. A typical one is a daisy chain, where each output waits for the one before it, possibly after a programmed settling delay. A software override can pin any output to a given level, for example to carry out an orderly power-down. The other cells see the pinned level as well.

Top module: `seqarr_macro_array`

## Requirements
- R1: While reset is high, and on the cycle after it falls, every delayed cell state is 0. With no override enabled, every output is therefore 0.
- R2: Term index s of cell i selects `ext_in[s]` for s < NUM_EXT, and the output of cell s-NUM_EXT for larger s. Its enable is `term_en[i*NUM_SRC+s]` and its inversion is `term_inv[i*NUM_SRC+s]`. The cell's logic value is 1 exactly when at least one term is enabled and every enabled term's source XOR its inversion bit is 1.
- R3: A cell with no enabled terms has a logic value of 0.
- R4: A cell's enable bit for its own output (index NUM_EXT+i) is ignored.
- R5: The rise delay code sits at `rise_codes[i*4+:4]`. Codes 0..15 select 0, 5, 10, 20, 30, 40, 50, 75, 100, 125, 150, 200, 250, 300, 400 and 500 ticks. When `tick` is high every cycle and a rising logic value is sampled at clock edge k, the output rises at edge k+D, where D is the tick count of the code.
- R6: The fall delay is chosen the same way by `fall_codes[i*4+:4]`, independently of the rise delay.
- R7: If the logic value returns to the current output before a pending delay expires, no transition happens. Once the logic value differs again, the delay count restarts from zero.
- R8: Delay time advances only on cycles where `tick` is high. While `tick` stays low, a pending transition never completes unless its delay is 0.
- R9: When `force_en[i]` is 1, `cell_out[i]` equals `force_val[i]` in the same cycle. That forced level is also the value other cells see as term NUM_EXT+i.
- R10: In a chain where each cell's only term is the previous cell's output, the outputs switch in order. Each stage adds its own delay plus one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per millisecond, the delay time base |
| ext_in | input | NUM_EXT | External fault and logic signals |
| term_en | input | NUM_CELLS*NUM_SRC | Per-cell term enables |
| term_inv | input | NUM_CELLS*NUM_SRC | Per-cell term inversions |
| rise_codes | input | NUM_CELLS*4 | Per-cell rising-edge delay codes |
| fall_codes | input | NUM_CELLS*4 | Per-cell falling-edge delay codes |
| force_en | input | NUM_CELLS | Per-output override enable |
| force_val | input | NUM_CELLS | Per-output override level |
| cell_out | output | NUM_CELLS | Final sequenced outputs |

## Verification
The bench uses the default parameters: twelve external inputs and nine cells, so each cell has 21 terms. With that width the random AND checks see a real mix of true and false cells. Most of the time `tick` is held high, which turns each delay code into an exact cycle count. This brings single-edge delays, aborted transitions and a four-stage chain with mixed delays within reach for cycle-exact checks. Self-term masking and override feedback are checked through the outputs of neighbouring cells.

// File: rtl/seqarr_pkg.sv
package seqarr_pkg;

    localparam int CODE_W       = 4;
    localparam int MAX_DELAY_MS = 500;
    localparam int DLY_W        = $clog2(MAX_DELAY_MS + 1);

    typedef logic [CODE_W-1:0] dly_code_t;
    typedef logic [DLY_W-1:0]  dly_ticks_t;

    typedef struct packed {
        dly_code_t rise;
        dly_code_t fall;
    } edge_cfg_t;

    function automatic dly_ticks_t code_to_ticks(input dly_code_t c);
        case (c)
            4'd0:    return dly_ticks_t'(0);
            4'd1:    return dly_ticks_t'(5);
            4'd2:    return dly_ticks_t'(10);
            4'd3:    return dly_ticks_t'(20);
            4'd4:    return dly_ticks_t'(30);
            4'd5:    return dly_ticks_t'(40);
            4'd6:    return dly_ticks_t'(50);
            4'd7:    return dly_ticks_t'(75);
            4'd8:    return dly_ticks_t'(100);
            4'd9:    return dly_ticks_t'(125);
            4'd10:   return dly_ticks_t'(150);
            4'd11:   return dly_ticks_t'(200);
            4'd12:   return dly_ticks_t'(250);
            4'd13:   return dly_ticks_t'(300);
            4'd14:   return dly_ticks_t'(400);
            default: return dly_ticks_t'(MAX_DELAY_MS);
        endcase
    endfunction

endpackage

// File: rtl/seqarr_term_and.sv
module seqarr_term_and #(
    parameter int NUM_SRC  = 21,
    parameter int SELF_IDX = 12
) (
    input  logic [NUM_SRC-1:0] src,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] inv,
    output logic               hit
);

    logic [NUM_SRC-1:0] en_eff;
    logic [NUM_SRC-1:0] pass;

    always_comb begin
        en_eff           = en;
        en_eff[SELF_IDX] = 1'b0;
        pass             = ~en_eff | (src ^ inv);
        hit              = (|en_eff) & (&pass);
    end

endmodule

// File: rtl/seqarr_edge_delay.sv
module seqarr_edge_delay
    import seqarr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      d,
    input  edge_cfg_t cfg,
    output logic      q
);

    logic       q_r;
    logic       differ;
    dly_ticks_t cnt;
    dly_ticks_t limit;

    assign differ = (d != q_r);
    assign q      = q_r;

    always_comb begin
        if (q_r) limit = code_to_ticks(cfg.fall);
        else     limit = code_to_ticks(cfg.rise);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= 1'b0;
            cnt <= '0;
        end else if (!differ) begin
            cnt <= '0;
        end else if (cnt >= limit) begin
            q_r <= d;
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7
    hold_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (d == q_r) |=> (q_r == $past(q_r)) && (cnt == '0));

    // R5
    zero_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (differ && limit == '0) |=> (q_r == $past(d)));

    // R8
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (differ && !tick && cnt < limit) |=> $stable(cnt) && $stable(q_r));

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= dly_ticks_t'(MAX_DELAY_MS));

endmodule

// File: rtl/seqarr_force_mux.sv
module seqarr_force_mux #(
    parameter int N = 9
) (
    input  logic [N-1:0] logic_in,
    input  logic [N-1:0] force_en,
    input  logic [N-1:0] force_val,
    output logic [N-1:0] out
);

    always_comb begin
        out = (force_en & force_val) | (~force_en & logic_in);
    end

endmodule

// File: rtl/seqarr_macro_array.sv
module seqarr_macro_array
    import seqarr_pkg::*;
#(
    parameter int NUM_EXT   = 12,
    parameter int NUM_CELLS = 9,
    localparam int NUM_SRC  = NUM_EXT + NUM_CELLS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick,
    input  logic [NUM_EXT-1:0]            ext_in,
    input  logic [NUM_CELLS*NUM_SRC-1:0]  term_en,
    input  logic [NUM_CELLS*NUM_SRC-1:0]  term_inv,
    input  logic [NUM_CELLS*CODE_W-1:0]   rise_codes,
    input  logic [NUM_CELLS*CODE_W-1:0]   fall_codes,
    input  logic [NUM_CELLS-1:0]          force_en,
    input  logic [NUM_CELLS-1:0]          force_val,
    output logic [NUM_CELLS-1:0]          cell_out
);

    logic [NUM_SRC-1:0]   src_vec;
    logic [NUM_CELLS-1:0] hit;
    logic [NUM_CELLS-1:0] dly_q;

    assign src_vec = {cell_out, ext_in};

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        edge_cfg_t cfg;

        assign cfg.rise = rise_codes[i*CODE_W +: CODE_W];
        assign cfg.fall = fall_codes[i*CODE_W +: CODE_W];

        seqarr_term_and #(
            .NUM_SRC  (NUM_SRC),
            .SELF_IDX (NUM_EXT + i)
        ) u_and (
            .src (src_vec),
            .en  (term_en [i*NUM_SRC +: NUM_SRC]),
            .inv (term_inv[i*NUM_SRC +: NUM_SRC]),
            .hit (hit[i])
        );

        seqarr_edge_delay u_dly (
            .clk  (clk),
            .rst  (rst),
            .tick (tick),
            .d    (hit[i]),
            .cfg  (cfg),
            .q    (dly_q[i])
        );
    end

    seqarr_force_mux #(.N(NUM_CELLS)) u_force (
        .logic_in  (dly_q),
        .force_en  (force_en),
        .force_val (force_val),
        .out       (cell_out)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (dly_q == '0));

    // R9
    out_stable_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(force_en) && $stable(force_val) && $stable(dly_q)) |-> $stable(cell_out));

endmodule

// File: tb/seqarr_macro_array_test.sv
module seqarr_macro_array_test;

    localparam int NE = 12;
    localparam int NC = 9;
    localparam int NS = NE + NC;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b1;
    logic [NE-1:0]    ext_in = '0;
    logic [NC*NS-1:0] term_en = '0;
    logic [NC*NS-1:0] term_inv = '0;
    logic [NC*4-1:0]  rise_codes = '0;
    logic [NC*4-1:0]  fall_codes = '0;
    logic [NC-1:0]    force_en = '0;
    logic [NC-1:0]    force_val = '0;
    logic [NC-1:0]    cell_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    seqarr_macro_array #(.NUM_EXT(NE), .NUM_CELLS(NC)) uut (
        .clk(clk), .rst(rst), .tick(tick), .ext_in(ext_in),
        .term_en(term_en), .term_inv(term_inv),
        .rise_codes(rise_codes), .fall_codes(fall_codes),
        .force_en(force_en), .force_val(force_val), .cell_out(cell_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int ms_of(input int code);
        case (code)
            0: return 0;     1: return 5;     2: return 10;    3: return 20;
            4: return 30;    5: return 40;    6: return 50;    7: return 75;
            8: return 100;   9: return 125;   10: return 150;  11: return 200;
            12: return 250;  13: return 300;  14: return 400;  default: return 500;
        endcase
    endfunction

    function automatic logic and_model(input logic [NS-1:0] en,
                                       input logic [NS-1:0] inv,
                                       input logic [NS-1:0] src);
        logic any_en = 1'b0;
        logic all_ok = 1'b1;
        for (int s = 0; s < NS; s++) begin
            if (en[s]) begin
                any_en = 1'b1;
                if ((src[s] ^ inv[s]) == 1'b0) all_ok = 1'b0;
            end
        end
        return any_en & all_ok;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick = 1'b1;
        ext_in = '0;
        term_en = '0;
        term_inv = '0;
        rise_codes = '0;
        fall_codes = '0;
        force_en = '0;
        force_val = '0;
        wait_edges(3);
        rst = 1'b0;
        wait_edges(1);
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd2024);
        @(negedge clk);
        do_reset();

        // R1: reset state
        for (int c = 0; c < NC; c++) chk("R1 reset output", cell_out[c], 1'b0);

        // R2 / R3: random AND patterns over external terms, zero delays
        for (int it = 0; it < 40; it++) begin
            logic [NE-1:0] ext_r;
            ext_r = NE'($urandom);
            for (int c = 0; c < NC; c++) begin
                logic [NE-1:0] en_r;
                logic [NE-1:0] inv_r;
                en_r = NE'($urandom) & NE'($urandom);
                if ($urandom % 2) inv_r = ~ext_r;
                else inv_r = NE'($urandom);
                if (c == 0 && (it % 2) == 0) en_r = '0;
                term_en [c*NS +: NS] = {{NC{1'b0}}, en_r};
                term_inv[c*NS +: NS] = {{NC{1'b0}}, inv_r};
            end
            ext_in = ext_r;
            wait_edges(2);
            for (int c = 0; c < NC; c++) begin
                logic exp_v;
                exp_v = and_model(term_en[c*NS +: NS], term_inv[c*NS +: NS],
                                  {{NC{1'b0}}, ext_in});
                if (term_en[c*NS +: NS] == '0) chk("R3 no terms", cell_out[c], 1'b0);
                else chk("R2 and pattern", cell_out[c], exp_v);
            end
        end

        // R4: self enable ignored
        do_reset();
        term_en[2*NS + 0] = 1'b1;
        term_en[2*NS + NE + 2] = 1'b1;
        ext_in[0] = 1'b1;
        wait_edges(2);
        chk("R4 self bit ignored", cell_out[2], 1'b1);
        term_en[2*NS + 0] = 1'b0;
        wait_edges(2);
        chk("R4 only self enabled", cell_out[2], 1'b0);

        // R5 / R6: rise and fall delays
        do_reset();
        term_en[0*NS + 0] = 1'b1;
        rise_codes[3:0] = 4'd3;
        wait_edges(2);
        ext_in[0] = 1'b1;
        wait_edges(ms_of(3));
        chk("R5 rise before delay", cell_out[0], 1'b0);
        wait_edges(1);
        chk("R5 rise at delay", cell_out[0], 1'b1);
        fall_codes[3:0] = 4'd2;
        ext_in[0] = 1'b0;
        wait_edges(ms_of(2));
        chk("R6 fall before delay", cell_out[0], 1'b1);
        wait_edges(1);
        chk("R6 fall at delay", cell_out[0], 1'b0);

        // R7: aborted transition and restart
        rise_codes[3:0] = 4'd4;
        ext_in[0] = 1'b1;
        wait_edges(15);
        ext_in[0] = 1'b0;
        wait_edges(40);
        chk("R7 aborted rise", cell_out[0], 1'b0);
        ext_in[0] = 1'b1;
        wait_edges(ms_of(4));
        chk("R7 restart full delay", cell_out[0], 1'b0);
        wait_edges(1);
        chk("R7 completes after restart", cell_out[0], 1'b1);

        // R8: tick gating
        fall_codes[3:0] = 4'd0;
        ext_in[0] = 1'b0;
        wait_edges(2);
        rise_codes[3:0] = 4'd2;
        tick = 1'b0;
        ext_in[0] = 1'b1;
        wait_edges(50);
        chk("R8 no ticks hold", cell_out[0], 1'b0);
        tick = 1'b1;
        wait_edges(ms_of(2));
        chk("R8 ticks before delay", cell_out[0], 1'b0);
        wait_edges(1);
        chk("R8 ticks at delay", cell_out[0], 1'b1);

        // R9: override and its feedback
        do_reset();
        term_en[6*NS + NE + 5] = 1'b1;
        force_en[5] = 1'b1;
        force_val[5] = 1'b1;
        #1;
        chk("R9 force same cycle", cell_out[5], 1'b1);
        wait_edges(2);
        chk("R9 forced level fed back", cell_out[6], 1'b1);
        force_val[5] = 1'b0;
        #1;
        chk("R9 force low", cell_out[5], 1'b0);
        wait_edges(2);
        chk("R9 forced low fed back", cell_out[6], 1'b0);
        term_en[4*NS + 3] = 1'b1;
        ext_in[3] = 1'b1;
        force_en[4] = 1'b1;
        force_val[4] = 1'b0;
        wait_edges(2);
        chk("R9 force overrides true logic", cell_out[4], 1'b0);
        force_en[4] = 1'b0;
        #1;
        chk("R9 release shows logic", cell_out[4], 1'b1);

        // R10: daisy chain with mixed delays
        do_reset();
        term_en[0*NS + 1] = 1'b1;       rise_codes[0*4 +: 4] = 4'd1;
        term_en[1*NS + NE + 0] = 1'b1;  rise_codes[1*4 +: 4] = 4'd0;
        term_en[2*NS + NE + 1] = 1'b1;  rise_codes[2*4 +: 4] = 4'd2;
        term_en[3*NS + NE + 2] = 1'b1;  rise_codes[3*4 +: 4] = 4'd1;
        wait_edges(2);
        ext_in[1] = 1'b1;
        begin
            int l1;
            int l2;
            int l3;
            l1 = (ms_of(1) + 1) + (ms_of(0) + 1);
            l2 = l1 + ms_of(2) + 1;
            l3 = l2 + ms_of(1) + 1;
            wait_edges(l1);
            chk("R10 stage1 on", cell_out[1], 1'b1);
            chk("R10 stage2 waiting", cell_out[2], 1'b0);
            wait_edges(l3 - 1 - l1);
            chk("R10 stage2 on", cell_out[2], 1'b1);
            chk("R10 stage3 waiting", cell_out[3], 1'b0);
            wait_edges(1);
            chk("R10 stage3 on", cell_out[3], 1'b1);
        end
        ext_in[1] = 1'b0;
        wait_edges(3);
        chk("R10 fall ripple stage3 still on", cell_out[3], 1'b1);
        chk("R10 fall ripple stage2 off", cell_out[2], 1'b0);
        wait_edges(1);
        chk("R10 fall ripple stage3 off", cell_out[3], 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule